// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of month, month, weekday number and a two-digit year. An external prescaler supplies a stream of enable pulses. After a parameterised number of those pulses (`SUB_TICKS`) the core advances one second. It then ripples the carry through the minutes, the hours and the calendar in the same clock edge.

Software loads any field through a one-cycle write strobe with a field selector. Every field is always visible on its own output bus. The hour byte has two formats, chosen by its top bit: a 12-hour form with an afternoon flag, and a 24-hour form. February length follows the leap rule for two-digit years. The top bit of the seconds byte stops the clock. A separate protect flag locks all time fields against writes.

Top module: `bcd_calendar_core`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Going from 59 to 00 advances the next field up in the same clock edge.
- R2: Hour bit 7 selects the format, 1 for 24-hour and 0 for 12-hour. It comes out of reset as 0 with the hour reading 0x12. Counting never changes this bit.
- R3: In 12-hour mode, bit 5 of the hour is the afternoon flag and bits 4:0 hold BCD 01–12. The hour steps 11 → 12 and toggles the flag, steps 12 → 01 without toggling it, and advances the date only on the step from 11 (flag set) to 12 (flag clear).
- R4: In 24-hour mode, bits 5:0 hold BCD 00–23, so 19 → 20 and 23 → 00. The step from 23 to 00 advances the date.
- R5: Months have 31/28/31/30/31/30/31/31/30/31/30/31 days. February has 29 days when the two-digit year is a multiple of 4, and year 00 counts as such a year.
- R6: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00. The weekday counts 01–07 and wraps from 07 to 01 at each date advance.
- R7: Seconds bit 7 is a halt flag. While it is set, no field counts and the sub-second phase holds. Reset sets it, so seconds read 0x80.
- R8: Field selector codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year and 7 control. Control bit 7 is the write lock, reset to 1, and it reads back on `wp_o`. While it is set, writes to codes 0–6 are dropped. A write to code 7 always succeeds.
- R9: Reset leaves seconds 0x80, minutes 0x00, hour 0x12, date 0x01, month 0x01, weekday 0x01 and year 0x00.
- R10: An accepted write to a time field appears on the next clock edge and takes precedence over a pulse in the same cycle; that pulse is dropped. A write to seconds also zeroes the sub-second phase.
- R11: When not halted, the seconds field advances on the edge that accepts the `SUB_TICKS`-th pulse since the phase was last zero. With no pulse and no write, seconds hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler enable pulse, one cycle wide |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Field selector code (see R8) |
| wr_data_i | input | 8 | Write value |
| sec_o | output | 8 | Seconds with halt flag in bit 7 |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour with format bit 7 |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| day_o | output | 8 | Weekday number |
| year_o | output | 8 | Two-digit year |
| wp_o | output | 1 | Write lock flag |

## Verification
Each result has a fixed due time:

- A write is due one edge after the edge that accepts it.
- A second is due on the edge that accepts the last of its pulses.
- Every carry into minutes, hours, date, month, weekday and year lands on that same edge, because the carry chain is purely combinational.

The driver changes inputs just after a rising edge and queues its expectations only after the edge on which they are due. The monitor compares them at the following falling edge, so no check depends on ordering at an edge. The dropped-pulse case is checked by a later pulse: seconds must advance exactly one pulse later than they would have if the dropped pulse had counted.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

   typedef enum logic [2:0] {
      F_SEC   = 3'd0,
      F_MIN   = 3'd1,
      F_HOUR  = 3'd2,
      F_DATE  = 3'd3,
      F_MONTH = 3'd4,
      F_DAY   = 3'd5,
      F_YEAR  = 3'd6,
      F_CTRL  = 3'd7
   } cal_field_e;

   localparam logic [7:0] SEC_RST   = 8'h80;
   localparam logic [7:0] MIN_RST   = 8'h00;
   localparam logic [7:0] HOUR_RST  = 8'h12;
   localparam logic [7:0] DATE_RST  = 8'h01;
   localparam logic [7:0] MONTH_RST = 8'h01;
   localparam logic [7:0] DAY_RST   = 8'h01;
   localparam logic [7:0] YEAR_RST  = 8'h00;

   // two-digit BCD increment without range check
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'h9) bcd_inc = {v[7:4] + 4'h1, 4'h0};
      else                bcd_inc = {v[7:4], v[3:0] + 4'h1};
   endfunction

   // year divisible by 4: even tens with units 0/4/8, odd tens with 2/6
   function automatic logic leap_year(input logic [7:0] y);
      if (y[4]) leap_year = (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
      else      leap_year = (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
      case (m)
         8'h02:                      month_len = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
         default:                    month_len = 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcd_cal_phase.sv
module bcd_cal_phase #(
   parameter int SUB_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   input  logic clear_i,
   output logic sec_pulse_o
);

   generate
      if (SUB_TICKS == 1) begin : g_direct
         assign sec_pulse_o = run_i & tick_i;
      end else begin : g_count
         localparam int PW = $clog2(SUB_TICKS);
         localparam logic [PW-1:0] LAST = PW'(SUB_TICKS - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                phase_q <= '0;
            else if (clear_i)          phase_q <= '0;
            else if (run_i && tick_i)  phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
         end

         assign sec_pulse_o = run_i & tick_i & (phase_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/bcd_cal_hour.sv
module bcd_cal_hour (
   input  logic       mode24_i,
   input  logic [5:0] hval_i,
   output logic [7:0] hour_nx_o,
   output logic       day_carry_o
);

   logic       pm;
   logic [4:0] h12;

   assign pm  = hval_i[5];
   assign h12 = hval_i[4:0];

   always_comb begin
      hour_nx_o   = {mode24_i, 1'b0, hval_i};
      day_carry_o = 1'b0;
      if (mode24_i) begin
         if (hval_i == 6'h23) begin
            hour_nx_o   = 8'h80;
            day_carry_o = 1'b1;
         end else if (hval_i[3:0] == 4'h9) begin
            hour_nx_o = {2'b10, hval_i[5:4] + 2'd1, 4'h0};
         end else begin
            hour_nx_o = {2'b10, hval_i[5:4], hval_i[3:0] + 4'h1};
         end
      end else begin
         if (h12 == 5'h11) begin
            hour_nx_o   = {2'b00, ~pm, 5'h12};
            day_carry_o = pm;
         end else if (h12 == 5'h12) begin
            hour_nx_o = {2'b00, pm, 5'h01};
         end else if (h12[3:0] == 4'h9) begin
            hour_nx_o = {2'b00, pm, 1'b1, 4'h0};
         end else begin
            hour_nx_o = {2'b00, pm, h12[4], h12[3:0] + 4'h1};
         end
      end
   end

endmodule

// File: rtl/bcd_cal_date.sv
module bcd_cal_date
   import bcd_cal_pkg::*;
(
   input  logic       adv_i,
   input  logic [7:0] date_i,
   input  logic [7:0] month_i,
   input  logic [7:0] year_i,
   input  logic [7:0] day_i,
   output logic [7:0] date_nx_o,
   output logic [7:0] month_nx_o,
   output logic [7:0] year_nx_o,
   output logic [7:0] day_nx_o
);

   logic [7:0] last_date;

   assign last_date = month_len(month_i, leap_year(year_i));

   always_comb begin
      date_nx_o  = date_i;
      month_nx_o = month_i;
      year_nx_o  = year_i;
      day_nx_o   = day_i;
      if (adv_i) begin
         day_nx_o = (day_i == 8'h07) ? 8'h01 : bcd_inc(day_i);
         if (date_i == last_date) begin
            date_nx_o = 8'h01;
            if (month_i == 8'h12) begin
               month_nx_o = 8'h01;
               year_nx_o  = (year_i == 8'h99) ? 8'h00 : bcd_inc(year_i);
            end else begin
               month_nx_o = bcd_inc(month_i);
            end
         end else begin
            date_nx_o = bcd_inc(date_i);
         end
      end
   end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
   import bcd_cal_pkg::*;
#(
   parameter int SUB_TICKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       wr_en_i,
   input  logic [2:0] wr_sel_i,
   input  logic [7:0] wr_data_i,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] date_o,
   output logic [7:0] month_o,
   output logic [7:0] day_o,
   output logic [7:0] year_o,
   output logic       wp_o
);

   generate
      if (SUB_TICKS < 1) begin : g_bad_sub_ticks
         $error("SUB_TICKS must be at least 1");
      end
   endgenerate

   cal_field_e sel;
   logic [7:0] sec_q, min_q, hour_q, date_q, month_q, day_q, year_q;
   logic       wp_q;
   logic       time_wr, sec_pulse, sec_wrap, min_wrap, hour_carry, date_adv;
   logic [7:0] hour_nx, date_nx, month_nx, year_nx, day_nx;

   assign sel      = cal_field_e'(wr_sel_i);
   assign time_wr  = wr_en_i & ~wp_q & (sel != F_CTRL);
   assign sec_wrap = (sec_q[6:0] == 7'h59);
   assign min_wrap = (min_q == 8'h59);
   assign date_adv = sec_pulse & sec_wrap & min_wrap & hour_carry;

   bcd_cal_phase #(.SUB_TICKS(SUB_TICKS)) phase_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (~sec_q[7] & ~time_wr),
      .tick_i      (tick_i),
      .clear_i     (time_wr & (sel == F_SEC)),
      .sec_pulse_o (sec_pulse)
   );

   bcd_cal_hour hour_i (
      .mode24_i    (hour_q[7]),
      .hval_i      (hour_q[5:0]),
      .hour_nx_o   (hour_nx),
      .day_carry_o (hour_carry)
   );

   bcd_cal_date date_i (
      .adv_i      (date_adv),
      .date_i     (date_q),
      .month_i    (month_q),
      .year_i     (year_q),
      .day_i      (day_q),
      .date_nx_o  (date_nx),
      .month_nx_o (month_nx),
      .year_nx_o  (year_nx),
      .day_nx_o   (day_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           wp_q <= 1'b1;
      else if (wr_en_i && sel == F_CTRL)    wp_q <= wr_data_i[7];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= SEC_RST;
         min_q   <= MIN_RST;
         hour_q  <= HOUR_RST;
         date_q  <= DATE_RST;
         month_q <= MONTH_RST;
         day_q   <= DAY_RST;
         year_q  <= YEAR_RST;
      end else if (time_wr) begin
         case (sel)
            F_SEC:   sec_q   <= wr_data_i;
            F_MIN:   min_q   <= wr_data_i;
            F_HOUR:  hour_q  <= wr_data_i;
            F_DATE:  date_q  <= wr_data_i;
            F_MONTH: month_q <= wr_data_i;
            F_DAY:   day_q   <= wr_data_i;
            F_YEAR:  year_q  <= wr_data_i;
            default: ;
         endcase
      end else if (sec_pulse) begin
         sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
         if (sec_wrap) begin
            min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
            if (min_wrap) begin
               hour_q  <= hour_nx;
               date_q  <= date_nx;
               month_q <= month_nx;
               year_q  <= year_nx;
               day_q   <= day_nx;
            end
         end
      end
   end

   assign sec_o   = sec_q;
   assign min_o   = min_q;
   assign hour_o  = hour_q;
   assign date_o  = date_q;
   assign month_o = month_q;
   assign day_o   = day_q;
   assign year_o  = year_q;
   assign wp_o    = wp_q;

endmodule

// File: rtl/bcd_calendar_core_chk.sv
module bcd_calendar_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       wr_en_i,
   input logic [2:0] wr_sel_i,
   input logic [7:0] wr_data_i,
   input logic [7:0] sec_o,
   input logic [7:0] min_o,
   input logic [7:0] hour_o,
   input logic [7:0] date_o,
   input logic [7:0] month_o,
   input logic [7:0] day_o,
   input logic [7:0] year_o,
   input logic       wp_o
);

   // R7
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_o[7] && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                                  $stable(date_o) && $stable(month_o) && $stable(day_o) &&
                                  $stable(year_o)));

   // R8
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_o && wr_en_i && wr_sel_i != 3'd7 && !tick_i) |=>
         ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o) &&
          $stable(month_o) && $stable(day_o) && $stable(year_o)));

   // R10
   sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_o && wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == $past(wr_data_i)));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o)));

   // R2
   mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && !wp_o && wr_sel_i == 3'd2) |=> (hour_o[7] == $past(hour_o[7])));

endmodule

bind bcd_calendar_core bcd_calendar_core_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .wr_en_i   (wr_en_i),
   .wr_sel_i  (wr_sel_i),
   .wr_data_i (wr_data_i),
   .sec_o     (sec_o),
   .min_o     (min_o),
   .hour_o    (hour_o),
   .date_o    (date_o),
   .month_o   (month_o),
   .day_o     (day_o),
   .year_o    (year_o),
   .wp_o      (wp_o)
);

// File: tb/bcd_calendar_core_tb_top.sv
module bcd_calendar_core_tb_top;
   import bcd_cal_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int SUB        = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] sec_o, min_o, hour_o, date_o, month_o, day_o, year_o;
   logic       wp_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_calendar_core #(.SUB_TICKS(SUB)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
      .date_o(date_o), .month_o(month_o), .day_o(day_o), .year_o(year_o), .wp_o(wp_o)
   );

   typedef struct {
      logic [2:0] sel;
      logic [7:0] exp;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   function automatic logic [7:0] field(input logic [2:0] s);
      case (s)
         3'd0: field = sec_o;
         3'd1: field = min_o;
         3'd2: field = hour_o;
         3'd3: field = date_o;
         3'd4: field = month_o;
         3'd5: field = day_o;
         3'd6: field = year_o;
         default: field = {wp_o, 7'b0};
      endcase
   endfunction

   task automatic push(input logic [2:0] s, input logic [7:0] e, input string tag);
      exp_t it;
      it.sel = s;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compares every queued expectation at the falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         checks++;
         if (field(it.sel) !== it.exp) begin
            errors++;
            $display("FAIL %s field %0d actual %h expected %h", it.tag, it.sel, field(it.sel), it.exp);
         end
      end
   end

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wr_tick(input logic [2:0] s, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d; tick = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(posedge clk); #1;
         tick = 1'b0;
      end
   endtask

   task automatic set_all(input logic [7:0] h, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] dy, input logic [7:0] yr);
      wr(F_YEAR, yr); wr(F_DAY, dy); wr(F_MONTH, mo); wr(F_DATE, dt); wr(F_HOUR, h);
      wr(F_MIN, 8'h59); wr(F_SEC, 8'h59);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9 reset defaults, R7 halt set, R2 12-hour, R8 lock set
      push(F_SEC,   8'h80, "R7");
      push(F_MIN,   8'h00, "R9");
      push(F_HOUR,  8'h12, "R2");
      push(F_DATE,  8'h01, "R9");
      push(F_MONTH, 8'h01, "R9");
      push(F_DAY,   8'h01, "R9");
      push(F_YEAR,  8'h00, "R9");
      push(F_CTRL,  8'h80, "R8");
      ticks(1);

      // R8 locked write dropped, then unlock
      wr(F_MIN, 8'h33);
      push(F_MIN, 8'h00, "R8");
      wr(F_CTRL, 8'h00);
      push(F_CTRL, 8'h00, "R8");

      // R7 halted: pulses do nothing
      ticks(2*SUB);
      push(F_SEC, 8'h80, "R7");
      push(F_MIN, 8'h00, "R7");

      // R10 write seconds; R11 seconds after SUB pulses; R1 rollover
      wr(F_SEC, 8'h58);
      push(F_SEC, 8'h58, "R10");
      ticks(SUB-1);
      push(F_SEC, 8'h58, "R11");
      ticks(1);
      push(F_SEC, 8'h59, "R11");
      ticks(SUB);
      push(F_SEC, 8'h00, "R1");
      push(F_MIN, 8'h01, "R1");

      // R10 seconds write clears phase
      ticks(2);
      wr(F_SEC, 8'h10);
      ticks(SUB-1);
      push(F_SEC, 8'h10, "R10");
      ticks(1);
      push(F_SEC, 8'h11, "R10");

      // R10 write wins over pulse, pulse dropped
      ticks(SUB-1);
      wr_tick(F_MIN, 8'h45);
      push(F_MIN, 8'h45, "R10");
      push(F_SEC, 8'h11, "R10");
      ticks(1);
      push(F_SEC, 8'h12, "R10");

      // R3 12-hour sequencing
      set_all(8'h11, 8'h15, 8'h06, 8'h03, 8'h24);
      ticks(SUB);
      push(F_HOUR, 8'h32, "R3");
      push(F_MIN,  8'h00, "R3");
      push(F_DATE, 8'h15, "R3");
      wr(F_MIN, 8'h59); wr(F_SEC, 8'h59);
      ticks(SUB);
      push(F_HOUR, 8'h21, "R3");
      push(F_DATE, 8'h15, "R3");
      set_all(8'h31, 8'h15, 8'h06, 8'h03, 8'h24);
      ticks(SUB);
      push(F_HOUR, 8'h12, "R3");
      push(F_DATE, 8'h16, "R3");
      push(F_DAY,  8'h04, "R6");

      // R4 24-hour
      set_all(8'h99, 8'h16, 8'h06, 8'h04, 8'h24);
      ticks(SUB);
      push(F_HOUR, 8'hA0, "R4");
      push(F_DATE, 8'h16, "R4");
      set_all(8'hA3, 8'h16, 8'h06, 8'h04, 8'h24);
      ticks(SUB);
      push(F_HOUR, 8'h80, "R4");
      push(F_DATE, 8'h17, "R4");
      push(F_DAY,  8'h05, "R4");

      // R5 leap year, R6 weekday wrap
      set_all(8'hA3, 8'h28, 8'h02, 8'h07, 8'h24);
      ticks(SUB);
      push(F_DATE,  8'h29, "R5");
      push(F_MONTH, 8'h02, "R5");
      push(F_DAY,   8'h01, "R6");
      wr(F_HOUR, 8'hA3); wr(F_MIN, 8'h59); wr(F_SEC, 8'h59);
      ticks(SUB);
      push(F_DATE,  8'h01, "R5");
      push(F_MONTH, 8'h03, "R5");
      set_all(8'hA3, 8'h28, 8'h02, 8'h02, 8'h23);
      ticks(SUB);
      push(F_DATE,  8'h01, "R5");
      push(F_MONTH, 8'h03, "R5");
      set_all(8'hA3, 8'h28, 8'h02, 8'h02, 8'h00);
      ticks(SUB);
      push(F_DATE,  8'h29, "R5");
      set_all(8'hA3, 8'h30, 8'h04, 8'h02, 8'h25);
      ticks(SUB);
      push(F_DATE,  8'h01, "R5");
      push(F_MONTH, 8'h05, "R5");

      // R6 year-end wrap
      set_all(8'hA3, 8'h31, 8'h12, 8'h06, 8'h99);
      ticks(SUB);
      push(F_DATE,  8'h01, "R6");
      push(F_MONTH, 8'h01, "R6");
      push(F_YEAR,  8'h00, "R6");
      push(F_DAY,   8'h07, "R6");

      // R8 relock
      wr(F_CTRL, 8'h80);
      wr(F_HOUR, 8'h05);
      push(F_HOUR, 8'h80, "R8");
      push(F_CTRL, 8'h80, "R8");

      @(negedge clk);
      #1;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule